// File: doc/BRIEF.md
# Interprocessor Destination Resolver

This block sits between the command registers of an interrupt controller and the fabric that reaches every processing agent. Software writes an interprocessor command as two 32-bit words. The high word holds the destination byte. The low word holds the vector, the delivery mode, the addressing mode and the shorthand. Writing the low word launches the command. One clock later the block presents a registered result: a bitmask that names the agents that must act, an action code that tells them what to do, and the vector and trigger bit that go with the command.

Every agent supplies a present flag, an 8-bit physical ID, an 8-bit logical destination byte and a 4-bit addressing-model nibble. The model nibble selects flat or cluster matching separately for each agent. A shorthand can override the destination field and select the sender, every agent, or every agent except the sender. For lowest-priority delivery the block keeps only the candidate with the lowest index. An INIT command that has level 0 and trigger 1 becomes a de-assert action. On that action each selected agent copies its physical ID into its arbitration ID. For a startup action each selected agent records the vector as its start vector. Handling inside each agent is outside this block.

Top module: `ipd_resolver`

## Requirements
- R1: A write with `wr_hi`=1 only stores the high word and raises no result. A write with `wr_hi`=0 launches a command. `out_valid` is then 1 in the cycle after that write edge and 0 in the cycle after that. While `out_valid` is 0, `out_action` is 0 and `out_mask` is 0. After reset the stored high word is 0 and all outputs are 0.
- R2: Field positions in the low word: bits 7:0 vector (output on `out_vector`), bits 10:8 delivery mode, bit 11 logical addressing, bit 14 level, bit 15 trigger (output on `out_trigger`), bits 19:18 shorthand. The destination byte is bits 31:24 of the stored high word.
- R3: Shorthand 1 selects only the sender (`sender_idx`). Shorthand 2 selects all agents. Shorthand 3 selects all agents except the sender. Shorthand 0 resolves the destination byte.
- R4: With physical addressing (bit 11 = 0), destination 0xFF selects all agents. Any other value selects the lowest-indexed agent whose physical ID equals the destination, or no agent if none matches.
- R5: With logical addressing, an agent whose model nibble is 0xF matches when the destination AND its logical byte is nonzero.
- R6: With logical addressing, an agent whose model nibble is 0x0 matches when the upper nibbles of the destination and the logical byte are equal and their lower nibbles share a set bit. An agent with any other model nibble never matches.
- R7: An agent with its present bit clear is never set in `out_mask`. This holds for every shorthand and addressing mode.
- R8: For delivery mode 1 (lowest priority), `out_mask` keeps only the lowest-indexed bit of the candidate mask, and `out_action` is 2.
- R9: Delivery mode 5 with level 0 and trigger 1 gives action 6 (INIT de-assert). Delivery mode 5 with any other level and trigger gives action 5 (INIT).
- R10: The action codes are as follows. Mode 0 gives action 1 (fixed). Mode 2 gives action 3 (SMI). Mode 4 gives action 4 (NMI). Mode 6 gives action 7 (startup), with the vector on `out_vector`. Modes 3 and 7 give action 0 and an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command word write strobe |
| wr_hi | input | 1 | 1 selects the high word, 0 the launching low word |
| wr_data | input | 32 | Command word data |
| sender_idx | input | IDXW | Index of the agent issuing the command |
| agent_present | input | N_AGENTS | Per-agent present flag |
| agent_phys_id | input | 8*N_AGENTS | Per-agent physical ID, agent i at bits 8i+7:8i |
| agent_log_dest | input | 8*N_AGENTS | Per-agent logical destination byte |
| agent_model | input | 4*N_AGENTS | Per-agent addressing model nibble |
| out_valid | output | 1 | Result strobe, one cycle per launch |
| out_action | output | 3 | Delivery action code |
| out_mask | output | N_AGENTS | Target agents |
| out_vector | output | 8 | Vector of the launched command |
| out_trigger | output | 1 | Trigger bit of the launched command |

## Verification
A launched command passes through exactly one register stage. Its mask, action, vector and trigger are therefore due in the cycle after the low-word write edge. The strobe must be low again one cycle later. A high-word write must leave the strobe low in the following cycle. The bench drives on falling edges and samples on the falling edge after the relevant rising edge. It checks the high-word case while the launch is being driven, the result one falling edge later, and the strobe drop on the falling edge after that. The agent configuration stays unchanged across each launch, so the expected result is computed from the same inputs the design registered.

// File: rtl/ipd_pkg.sv
package ipd_pkg;

    localparam logic [2:0] DM_FIXED   = 3'd0;
    localparam logic [2:0] DM_LOWPRI  = 3'd1;
    localparam logic [2:0] DM_SMI     = 3'd2;
    localparam logic [2:0] DM_NMI     = 3'd4;
    localparam logic [2:0] DM_INIT    = 3'd5;
    localparam logic [2:0] DM_STARTUP = 3'd6;

    localparam logic [1:0] SH_NONE      = 2'd0;
    localparam logic [1:0] SH_SELF      = 2'd1;
    localparam logic [1:0] SH_ALL       = 2'd2;
    localparam logic [1:0] SH_ALL_OTHER = 2'd3;

    localparam logic [7:0] PHYS_BCAST = 8'hFF;
    localparam logic [3:0] MODEL_FLAT = 4'hF;
    localparam logic [3:0] MODEL_CLUS = 4'h0;

    typedef enum logic [2:0] {
        ACT_NONE     = 3'd0,
        ACT_FIXED    = 3'd1,
        ACT_LOWPRI   = 3'd2,
        ACT_SMI      = 3'd3,
        ACT_NMI      = 3'd4,
        ACT_INIT     = 3'd5,
        ACT_INIT_DEA = 3'd6,
        ACT_STARTUP  = 3'd7
    } act_e;

    typedef struct packed {
        logic [7:0] vector;
        logic [2:0] dmode;
        logic       logical;
        logic       level;
        logic       trig;
        logic [1:0] shorthand;
        logic [7:0] dest;
    } cmd_t;

    function automatic cmd_t unpack_cmd(input logic [31:0] lo, input logic [31:0] hi);
        cmd_t c;
        c.vector    = lo[7:0];
        c.dmode     = lo[10:8];
        c.logical   = lo[11];
        c.level     = lo[14];
        c.trig      = lo[15];
        c.shorthand = lo[19:18];
        c.dest      = hi[31:24];
        return c;
    endfunction

    function automatic logic logical_hit(input logic [7:0] dest,
                                         input logic [7:0] ldest,
                                         input logic [3:0] model);
        if (model == MODEL_FLAT)
            return |(dest & ldest);
        else if (model == MODEL_CLUS)
            return (dest[7:4] == ldest[7:4]) && |(dest[3:0] & ldest[3:0]);
        else
            return 1'b0;
    endfunction

endpackage

// File: rtl/ipd_cmd_regs.sv
module ipd_cmd_regs (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic [31:0] wr_data,
    output logic [31:0] hi_word,
    output logic [31:0] lo_word,
    output logic        launch
);
    always_ff @(posedge clk) begin
        if (rst)
            hi_word <= '0;
        else if (wr_en && wr_hi)
            hi_word <= wr_data;
    end

    assign launch  = wr_en && !wr_hi;
    assign lo_word = wr_data;
endmodule

// File: rtl/ipd_dest_match.sv
module ipd_dest_match
    import ipd_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDXW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  cmd_t                    cmd,
    input  logic [IDXW-1:0]         sender_idx,
    input  logic [N_AGENTS-1:0]     present,
    input  logic [8*N_AGENTS-1:0]   phys_id,
    input  logic [8*N_AGENTS-1:0]   log_dest,
    input  logic [4*N_AGENTS-1:0]   model,
    output logic [N_AGENTS-1:0]     mask
);
    logic [N_AGENTS-1:0] id_hit;
    logic [N_AGENTS-1:0] log_hit;
    logic [N_AGENTS-1:0] is_self;
    logic [N_AGENTS-1:0] uni;

    for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
        assign id_hit[g]  = (phys_id[8*g +: 8] == cmd.dest);
        assign log_hit[g] = logical_hit(cmd.dest, log_dest[8*g +: 8], model[4*g +: 4]);
        assign is_self[g] = (sender_idx == IDXW'(g));
    end

    assign uni = id_hit & (~id_hit + N_AGENTS'(1));

    logic [N_AGENTS-1:0] raw;
    always_comb begin
        case (cmd.shorthand)
            SH_SELF:      raw = is_self;
            SH_ALL:       raw = '1;
            SH_ALL_OTHER: raw = ~is_self;
            default: begin
                if (cmd.logical)
                    raw = log_hit;
                else if (cmd.dest == PHYS_BCAST)
                    raw = '1;
                else
                    raw = uni;
            end
        endcase
    end

    assign mask = raw & present;
endmodule

// File: rtl/ipd_action.sv
module ipd_action
    import ipd_pkg::*;
#(
    parameter int N_AGENTS = 8
) (
    input  cmd_t                cmd,
    input  logic [N_AGENTS-1:0] cand,
    output act_e                act,
    output logic [N_AGENTS-1:0] mask
);
    logic [N_AGENTS-1:0] lowest;
    assign lowest = cand & (~cand + N_AGENTS'(1));

    always_comb begin
        act  = ACT_NONE;
        mask = cand;
        case (cmd.dmode)
            DM_FIXED:   act = ACT_FIXED;
            DM_LOWPRI: begin
                act  = ACT_LOWPRI;
                mask = lowest;
            end
            DM_SMI:     act = ACT_SMI;
            DM_NMI:     act = ACT_NMI;
            DM_INIT:    act = (!cmd.level && cmd.trig) ? ACT_INIT_DEA : ACT_INIT;
            DM_STARTUP: act = ACT_STARTUP;
            default: begin
                act  = ACT_NONE;
                mask = '0;
            end
        endcase
    end
endmodule

// File: rtl/ipd_resolver.sv
module ipd_resolver
    import ipd_pkg::*;
#(
    parameter int N_AGENTS = 8,
    localparam int IDXW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  wr_hi,
    input  logic [31:0]           wr_data,
    input  logic [IDXW-1:0]       sender_idx,
    input  logic [N_AGENTS-1:0]   agent_present,
    input  logic [8*N_AGENTS-1:0] agent_phys_id,
    input  logic [8*N_AGENTS-1:0] agent_log_dest,
    input  logic [4*N_AGENTS-1:0] agent_model,
    output logic                  out_valid,
    output logic [2:0]            out_action,
    output logic [N_AGENTS-1:0]   out_mask,
    output logic [7:0]            out_vector,
    output logic                  out_trigger
);
    logic [31:0] hi_word, lo_word;
    logic        launch;
    cmd_t        cmd;
    logic [N_AGENTS-1:0] cand, fin_mask;
    act_e        act;

    ipd_cmd_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
        .hi_word(hi_word), .lo_word(lo_word), .launch(launch)
    );

    assign cmd = unpack_cmd(lo_word, hi_word);

    ipd_dest_match #(.N_AGENTS(N_AGENTS)) u_match (
        .cmd(cmd), .sender_idx(sender_idx), .present(agent_present),
        .phys_id(agent_phys_id), .log_dest(agent_log_dest), .model(agent_model),
        .mask(cand)
    );

    ipd_action #(.N_AGENTS(N_AGENTS)) u_act (
        .cmd(cmd), .cand(cand), .act(act), .mask(fin_mask)
    );

    always_ff @(posedge clk) begin
        if (rst || !launch) begin
            out_valid   <= 1'b0;
            out_action  <= ACT_NONE;
            out_mask    <= '0;
            out_vector  <= '0;
            out_trigger <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            out_action  <= act;
            out_mask    <= fin_mask;
            out_vector  <= cmd.vector;
            out_trigger <= cmd.trig;
        end
    end
endmodule

// File: rtl/ipd_resolver_chk.sv
module ipd_resolver_chk #(
    parameter int N_AGENTS = 8,
    localparam int IDXW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic                  wr_hi,
    input logic [31:0]           wr_data,
    input logic [IDXW-1:0]       sender_idx,
    input logic [N_AGENTS-1:0]   agent_present,
    input logic [8*N_AGENTS-1:0] agent_phys_id,
    input logic [8*N_AGENTS-1:0] agent_log_dest,
    input logic [4*N_AGENTS-1:0] agent_model,
    input logic                  out_valid,
    input logic [2:0]            out_action,
    input logic [N_AGENTS-1:0]   out_mask,
    input logic [7:0]            out_vector,
    input logic                  out_trigger
);
    a_r1_launch_valid: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hi) |=> out_valid);

    a_r1_hi_silent: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || wr_hi) |=> !out_valid);

    a_r1_idle_empty: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_mask == '0 && out_action == 3'd0));

    a_r2_vector_carry: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hi) |=> (out_vector == $past(wr_data[7:0])));

    a_r7_absent_clear: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_mask & ~$past(agent_present)) == '0));

    a_r8_single_lowpri: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_action == 3'd2) |-> $onehot0(out_mask));

    a_r3_self_only: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_hi && wr_data[19:18] == 2'd1) |=> ($countones(out_mask) <= 1));

    a_r10_none_empty: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_action == 3'd0) |-> (out_mask == '0));
endmodule

bind ipd_resolver ipd_resolver_chk #(.N_AGENTS(N_AGENTS)) u_chk (.*);

// File: tb/tb_ipd_resolver.sv
module tb_ipd_resolver;
    localparam int N = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_hi = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [IW-1:0] sender_idx = '0;
    logic [N-1:0]  agent_present = '1;
    logic [8*N-1:0] agent_phys_id = '0;
    logic [8*N-1:0] agent_log_dest = '0;
    logic [4*N-1:0] agent_model = '0;
    logic          out_valid;
    logic [2:0]    out_action;
    logic [N-1:0]  out_mask;
    logic [7:0]    out_vector;
    logic          out_trigger;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    ipd_resolver #(.N_AGENTS(N)) dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic lhit(input logic [7:0] d, input logic [7:0] l, input logic [3:0] m);
        if (m == 4'hF) return (d & l) != 0;
        if (m == 4'h0) return (d[7:4] == l[7:4]) && ((d[3:0] & l[3:0]) != 0);
        return 1'b0;
    endfunction

    // expected {action, mask}
    function automatic logic [2+N:0] expect_res(input logic [31:0] lo, input logic [31:0] hi);
        logic [N-1:0] m = '0;
        logic [2:0] a;
        logic [7:0] d = hi[31:24];
        bit found = 0;
        for (int i = 0; i < N; i++) begin
            case (lo[19:18])
                2'd1: m[i] = (i == int'(sender_idx));
                2'd2: m[i] = 1'b1;
                2'd3: m[i] = (i != int'(sender_idx));
                default: begin
                    if (lo[11]) m[i] = lhit(d, agent_log_dest[8*i +: 8], agent_model[4*i +: 4]);
                    else if (d == 8'hFF) m[i] = 1'b1;
                    else if (!found && agent_phys_id[8*i +: 8] == d) begin
                        m[i] = 1'b1;
                        found = 1;
                    end
                end
            endcase
        end
        m &= agent_present;
        case (lo[10:8])
            3'd0: a = 3'd1;
            3'd1: begin
                a = 3'd2;
                found = 0;
                for (int i = 0; i < N; i++) begin
                    if (m[i] && !found) found = 1;
                    else m[i] = 1'b0;
                end
            end
            3'd2: a = 3'd3;
            3'd4: a = 3'd4;
            3'd5: a = (!lo[14] && lo[15]) ? 3'd6 : 3'd5;
            3'd6: a = 3'd7;
            default: begin a = 3'd0; m = '0; end
        endcase
        return {a, m};
    endfunction

    task automatic send(input logic [31:0] hi, input logic [31:0] lo, input string req);
        logic [2+N:0] e;
        @(negedge clk);
        wr_en = 1; wr_hi = 1; wr_data = hi;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 high write valid", {31'd0, out_valid}, 0);
        wr_hi = 0; wr_data = lo;
        e = expect_res(lo, hi);
        @(negedge clk);
        wr_en = 0; wr_data = '0;
        check(out_valid == 1'b1, "R1 launch valid", {31'd0, out_valid}, 1);
        check(out_action == e[N+2:N], {req, " action"}, {29'd0, out_action}, {29'd0, e[N+2:N]});
        check(out_mask == e[N-1:0], {req, " mask"}, {24'd0, out_mask}, {24'd0, e[N-1:0]});
        check(out_vector == lo[7:0] && out_trigger == lo[15], "R2 vector/trigger",
              {23'd0, out_trigger, out_vector}, {23'd0, lo[15], lo[7:0]});
        @(negedge clk);
        check(out_valid == 1'b0 && out_mask == '0, "R1 strobe drop", {23'd0, out_valid, out_mask}, 0);
    endtask

    function automatic logic [31:0] mklo(input logic [7:0] v, input logic [2:0] dm, input bit lg,
                                         input bit lvl, input bit tr, input logic [1:0] sh);
        return {12'd0, sh, 2'd0, tr, lvl, 2'd0, lg, dm, v};
    endfunction

    initial begin
        int unused;
        unused = $urandom(32'h5EED1234);
        for (int i = 0; i < N; i++) begin
            agent_phys_id[8*i +: 8]  = 8'(i + 1);
            agent_log_dest[8*i +: 8] = 8'(1 << i);
            agent_model[4*i +: 4]    = 4'hF;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(out_valid == 0 && out_mask == 0 && out_action == 0, "R1 reset state",
              {20'd0, out_valid, out_action, out_mask}, 0);

        // physical broadcast and unicast, duplicate IDs
        send(32'hFF00_0000, mklo(8'h31, 3'd0, 0, 1, 0, 2'd0), "R4 bcast");
        agent_phys_id[8*5 +: 8] = 8'h03;
        send(32'h0300_0000, mklo(8'h32, 3'd0, 0, 1, 0, 2'd0), "R4 dup id lowest");
        send(32'h7700_0000, mklo(8'h33, 3'd0, 0, 1, 0, 2'd0), "R4 no match");
        // flat logical
        send(32'h2400_0000, mklo(8'h40, 3'd4, 1, 1, 0, 2'd0), "R5 flat");
        // cluster logical plus a non-matching model
        agent_model[4*1 +: 4] = 4'h0; agent_log_dest[8*1 +: 8] = 8'h52;
        agent_model[4*2 +: 4] = 4'h0; agent_log_dest[8*2 +: 8] = 8'h62;
        agent_model[4*3 +: 4] = 4'h7; agent_log_dest[8*3 +: 8] = 8'hFF;
        send(32'h5300_0000, mklo(8'h41, 3'd0, 1, 1, 0, 2'd0), "R6 cluster");
        send(32'hFF00_0000, mklo(8'h42, 3'd0, 1, 1, 0, 2'd0), "R6 other model");
        // shorthands, absent sender
        sender_idx = 3'd4;
        send(32'h0, mklo(8'h50, 3'd0, 0, 1, 0, 2'd1), "R3 self");
        send(32'h0, mklo(8'h51, 3'd0, 0, 1, 0, 2'd2), "R3 all");
        send(32'h0, mklo(8'h52, 3'd0, 0, 1, 0, 2'd3), "R3 all but self");
        agent_present = 8'b1110_1010;
        send(32'h0, mklo(8'h53, 3'd0, 0, 1, 0, 2'd1), "R7 absent self");
        send(32'hFF00_0000, mklo(8'h54, 3'd2, 0, 1, 0, 2'd0), "R7 bcast absent");
        // lowest priority
        send(32'hFF00_0000, mklo(8'h60, 3'd1, 0, 1, 0, 2'd0), "R8 lowpri");
        send(32'h0, mklo(8'h61, 3'd1, 0, 1, 0, 2'd3), "R8 lowpri others");
        // INIT variants
        send(32'hFF00_0000, mklo(8'h00, 3'd5, 0, 0, 1, 2'd0), "R9 deassert");
        send(32'hFF00_0000, mklo(8'h00, 3'd5, 0, 1, 1, 2'd0), "R9 init");
        send(32'hFF00_0000, mklo(8'h00, 3'd5, 0, 0, 0, 2'd0), "R9 init edge");
        // startup, extint, undefined
        send(32'hFF00_0000, mklo(8'h9A, 3'd6, 0, 1, 0, 2'd0), "R10 startup");
        send(32'hFF00_0000, mklo(8'h9B, 3'd7, 0, 1, 0, 2'd0), "R10 ext none");
        send(32'hFF00_0000, mklo(8'h9C, 3'd3, 0, 1, 0, 2'd2), "R10 undefined");

        // constrained random
        for (int t = 0; t < 300; t++) begin
            for (int i = 0; i < N; i++) begin
                logic [3:0] mr;
                agent_phys_id[8*i +: 8]  = 8'($urandom_range(0, 9));
                agent_log_dest[8*i +: 8] = 8'($urandom);
                mr = 4'($urandom_range(0, 3));
                agent_model[4*i +: 4] = (mr < 2) ? 4'hF : (mr == 2) ? 4'h0 : 4'($urandom);
            end
            agent_present = 8'($urandom) | 8'($urandom);
            sender_idx = 3'($urandom);
            begin
                logic [31:0] hi, lo;
                hi = {($urandom_range(0, 4) == 0) ? 8'hFF : 8'($urandom), 24'($urandom)};
                lo = $urandom;
                send(hi, lo, "R2 random");
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule